// File: doc/BRIEF.md
# Execute-Stage ALU with Register Writeback

This block is the integer execute stage of a small 32-bit processor. The decoder hands it one instruction at a time. Each instruction carries two 32-bit operands, a 6-bit operation code and a 6-bit destination register index. The block latches the instruction and computes the result. It then makes a single write request to the register file and, one cycle after that write, raises a one-cycle completion strobe.

The block supports eleven operations:

- wrapping add and subtract
- bitwise AND, OR and XOR
- a bit-clear that removes from operand B every bit that is set in operand A
- equality, signed less-than and unsigned less-than, each giving a 0/1 word
- forwarding of operand A or of operand B

Any other operation code is refused. For such a code the block raises a one-cycle illegal-operation pulse. It does not write and does not complete.

While an instruction is in flight, the `busy` output is high and new issue requests are ignored.

Top module: `alu_exec_stage`

## Requirements
- R1: Operation codes are 6 bits: ADD=0, SUB=1, AND=2, OR=3, CLR=4, EQ=5, LT=6, LTU=7, XOR=8, OPA=9, OPB=10. ADD and SUB write (a+b) and (a-b) modulo 2^32, with no flags.
- R2: AND, OR and XOR write the bitwise AND, OR and XOR of the operands.
- R3: CLR writes b & ~a.
- R4: EQ, LT and LTU write 32'd1 when the comparison holds and 32'd0 otherwise. LT compares the operands as signed two's-complement values; LTU compares them as unsigned values.
- R5: OPA writes operand a unchanged and OPB writes operand b unchanged.
- R6: An issue is accepted at a clock edge where `issue_valid` is 1 and `busy` is 0. For a legal code, `wb_en` is high for exactly one cycle, in the second cycle after the accepting edge. Each completed instruction has exactly one write.
- R7: `wb_addr` during the write equals the destination index given at acceptance.
- R8: `retire` is a one-cycle pulse in the cycle directly after the write cycle.
- R9: Codes 11 to 63 give a one-cycle `bad_op` pulse in the second cycle after acceptance. No write and no `retire` are issued for them.
- R10: `busy` is 1 from the cycle after acceptance until `retire` or `bad_op` has been shown. Any `issue_valid` while `busy` is 1 is ignored.
- R11: A synchronous active-high `rst` clears all state. No `wb_en`, `retire` or `bad_op` is issued in a cycle that follows a reset edge, and `busy` reads 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Decoded instruction present |
| src_a | input | 32 | Operand A |
| src_b | input | 32 | Operand B |
| op_sel | input | 6 | Operation code |
| dest_idx | input | 6 | Destination register index |
| busy | output | 1 | Instruction in flight |
| wb_en | output | 1 | Register-file write enable |
| wb_addr | output | 6 | Register-file write address |
| wb_data | output | 32 | Register-file write data |
| retire | output | 1 | Instruction-complete strobe |
| bad_op | output | 1 | Illegal operation code pulse |

## Verification
The hardest case to reach from the ports is an issue request that arrives while an earlier instruction is still in flight. A correct design must neither overwrite the latched operands nor produce a second write. The bench covers this by holding `issue_valid` high, with a different operation and destination, through the execute, write and retire cycles. It then checks that only the first instruction's data and address reach the write port.

A reset asserted between acceptance and the write cycle is driven in the same way, to show that the pending write is dropped.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int XLEN     = 32;
    localparam int OPW      = 6;
    localparam int REGW     = 6;
    localparam int NUM_OPS  = 11;

    typedef enum logic [OPW-1:0] {
        OP_ADD = 6'd0,
        OP_SUB = 6'd1,
        OP_AND = 6'd2,
        OP_OR  = 6'd3,
        OP_CLR = 6'd4,
        OP_EQ  = 6'd5,
        OP_LT  = 6'd6,
        OP_LTU = 6'd7,
        OP_XOR = 6'd8,
        OP_OPA = 6'd9,
        OP_OPB = 6'd10
    } alu_op_e;

    typedef struct packed {
        logic [OPW-1:0]  op;
        logic [XLEN-1:0] a;
        logic [XLEN-1:0] b;
        logic [REGW-1:0] dest;
    } alu_instr_t;

    typedef struct packed {
        logic            legal;
        logic [XLEN-1:0] value;
    } alu_result_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EXEC,
        ST_WRITE,
        ST_DONE,
        ST_FAULT
    } seq_state_e;

    function automatic logic [XLEN-1:0] flag_word(input logic f);
        return {{(XLEN-1){1'b0}}, f};
    endfunction

    function automatic alu_result_t alu_eval(input alu_instr_t ins);
        alu_result_t r;
        r.legal = (ins.op < OPW'(NUM_OPS));
        r.value = '0;
        case (ins.op)
            OP_ADD: r.value = ins.a + ins.b;
            OP_SUB: r.value = ins.a - ins.b;
            OP_AND: r.value = ins.a & ins.b;
            OP_OR:  r.value = ins.a | ins.b;
            OP_CLR: r.value = ins.b & ~ins.a;
            OP_EQ:  r.value = flag_word(ins.a == ins.b);
            OP_LT:  r.value = flag_word($signed(ins.a) < $signed(ins.b));
            OP_LTU: r.value = flag_word(ins.a < ins.b);
            OP_XOR: r.value = ins.a ^ ins.b;
            OP_OPA: r.value = ins.a;
            OP_OPB: r.value = ins.b;
            default: r.value = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/alu_issue_latch.sv
module alu_issue_latch
    import alu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  alu_instr_t in_instr,
    output alu_instr_t held
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else if (load) begin
            held <= in_instr;
        end
    end
endmodule

// File: rtl/alu_compute.sv
module alu_compute
    import alu_pkg::*;
(
    input  alu_instr_t  instr,
    output alu_result_t res
);
    always_comb begin
        res = alu_eval(instr);
    end
endmodule

// File: rtl/alu_wb_seq.sv
module alu_wb_seq
    import alu_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  alu_result_t     res,
    input  logic [REGW-1:0] dest,
    output logic            busy,
    output logic            wb_en,
    output logic [REGW-1:0] wb_addr,
    output logic [XLEN-1:0] wb_data,
    output logic            retire,
    output logic            bad_op
);
    seq_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            wb_addr <= '0;
            wb_data <= '0;
        end else begin
            case (state)
                ST_IDLE:  if (start) state <= ST_EXEC;
                ST_EXEC: begin
                    if (res.legal) begin
                        state   <= ST_WRITE;
                        wb_addr <= dest;
                        wb_data <= res.value;
                    end else begin
                        state <= ST_FAULT;
                    end
                end
                ST_WRITE: state <= ST_DONE;
                ST_DONE:  state <= ST_IDLE;
                ST_FAULT: state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    assign busy   = (state != ST_IDLE);
    assign wb_en  = (state == ST_WRITE);
    assign retire = (state == ST_DONE);
    assign bad_op = (state == ST_FAULT);
endmodule

// File: rtl/alu_exec_stage.sv
module alu_exec_stage
    import alu_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            issue_valid,
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    input  logic [OPW-1:0]  op_sel,
    input  logic [REGW-1:0] dest_idx,
    output logic            busy,
    output logic            wb_en,
    output logic [REGW-1:0] wb_addr,
    output logic [XLEN-1:0] wb_data,
    output logic            retire,
    output logic            bad_op
);
    alu_instr_t  incoming;
    alu_instr_t  held;
    alu_result_t res;
    logic        accept;

    assign accept   = issue_valid && !busy;
    assign incoming = '{op: op_sel, a: src_a, b: src_b, dest: dest_idx};

    alu_issue_latch u_latch (
        .clk(clk), .rst(rst), .load(accept), .in_instr(incoming), .held(held)
    );

    alu_compute u_compute (
        .instr(held), .res(res)
    );

    alu_wb_seq u_seq (
        .clk(clk), .rst(rst), .start(accept), .res(res), .dest(held.dest),
        .busy(busy), .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data),
        .retire(retire), .bad_op(bad_op)
    );
endmodule

// File: rtl/alu_exec_stage_chk.sv
module alu_exec_stage_chk
    import alu_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            issue_valid,
    input logic [OPW-1:0]  op_sel,
    input logic [REGW-1:0] dest_idx,
    input logic            busy,
    input logic            wb_en,
    input logic [REGW-1:0] wb_addr,
    input logic [XLEN-1:0] wb_data,
    input logic            retire,
    input logic            bad_op
);
    logic [1:0]      wr_cnt;
    logic [REGW-1:0] exp_dest;
    logic [OPW-1:0]  exp_op;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_cnt   <= '0;
            exp_dest <= '0;
            exp_op   <= '0;
        end else begin
            if (issue_valid && !busy) begin
                exp_dest <= dest_idx;
                exp_op   <= op_sel;
            end
            if (retire || bad_op) wr_cnt <= '0;
            else if (wb_en && wr_cnt != 2'd3) wr_cnt <= wr_cnt + 2'd1;
        end
    end

    AST_ONE_WRITE: assert property (@(posedge clk) disable iff (rst)
        retire |-> wr_cnt == 2'd1); // R6
    AST_WB_ADDR: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> wb_addr == exp_dest); // R7
    AST_RETIRE_AFTER_WB: assert property (@(posedge clk) disable iff (rst)
        wb_en |=> retire); // R8
    AST_RETIRE_PULSE: assert property (@(posedge clk) disable iff (rst)
        retire |=> !retire); // R8
    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (rst)
        bad_op |-> (!wb_en && !retire && wr_cnt == 2'd0)); // R9
    AST_CMP_BOOL: assert property (@(posedge clk) disable iff (rst)
        (wb_en && (exp_op == OP_EQ || exp_op == OP_LT || exp_op == OP_LTU))
        |-> wb_data[XLEN-1:1] == '0); // R4
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> busy); // R10
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!wb_en && !retire && !bad_op && !busy)); // R11
endmodule

bind alu_exec_stage alu_exec_stage_chk i_chk (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .op_sel(op_sel),
    .dest_idx(dest_idx), .busy(busy), .wb_en(wb_en), .wb_addr(wb_addr),
    .wb_data(wb_data), .retire(retire), .bad_op(bad_op)
);

// File: tb/test_alu_exec_stage.sv
`timescale 1ns/1ps
module test_alu_exec_stage;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue_valid = 1'b0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [5:0]  op_sel = '0;
    logic [5:0]  dest_idx = '0;
    logic        busy, wb_en, retire, bad_op;
    logic [5:0]  wb_addr;
    logic [31:0] wb_data;

    int errors = 0;
    int checks = 0;
    int wr_seen = 0;
    bit done = 0;

    always #5 clk = ~clk;

    alu_exec_stage i_alu_exec_stage (
        .clk(clk), .rst(rst), .issue_valid(issue_valid), .src_a(src_a),
        .src_b(src_b), .op_sel(op_sel), .dest_idx(dest_idx), .busy(busy),
        .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data),
        .retire(retire), .bad_op(bad_op)
    );

    always @(posedge clk) if (!rst && wb_en) wr_seen++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic issue(input logic [5:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic [5:0] d);
        op_sel = op; src_a = a; src_b = b; dest_idx = d;
        issue_valid = 1'b1;
        step();
        issue_valid = 1'b0;
    endtask

    task automatic run_op(input string req, input logic [5:0] op, input logic [31:0] a,
                          input logic [31:0] b, input logic [5:0] d, input logic [31:0] exp);
        int w0;
        w0 = wr_seen;
        issue(op, a, b, d);
        chk({req, " busy after accept (R10)"}, busy, 1);
        chk({req, " no early write (R6)"}, wb_en, 0);
        step();
        chk({req, " write enable (R6)"}, wb_en, 1);
        chk({req, " data"}, wb_data, exp);
        chk({req, " address (R7)"}, wb_addr, d);
        chk({req, " no retire in write cycle (R8)"}, retire, 0);
        step();
        chk({req, " retire pulse (R8)"}, retire, 1);
        chk({req, " write dropped (R6)"}, wb_en, 0);
        step();
        chk({req, " retire one cycle (R8)"}, retire, 0);
        chk({req, " idle (R10)"}, busy, 0);
        chk({req, " one write (R6)"}, wr_seen - w0, 1);
    endtask

    task automatic t_reset();
        step(); step();
        rst = 1'b0;
        chk("R11 busy after reset", busy, 0);
        chk("R11 no write after reset", wb_en, 0);
        chk("R11 no retire after reset", retire, 0);
        chk("R11 no bad_op after reset", bad_op, 0);
    endtask

    task automatic t_arith();
        run_op("R1 add", 6'd0, 32'h0000_0005, 32'h0000_0007, 6'd3, 32'd12);
        run_op("R1 add wrap", 6'd0, 32'hFFFF_FFFF, 32'h0000_0002, 6'd4, 32'd1);
        run_op("R1 sub", 6'd1, 32'd10, 32'd3, 6'd5, 32'd7);
        run_op("R1 sub wrap", 6'd1, 32'd0, 32'd1, 6'd63, 32'hFFFF_FFFF);
    endtask

    task automatic t_logic();
        run_op("R2 and", 6'd2, 32'hF0F0_FF00, 32'h3C3C_0FF0, 6'd1, 32'h3030_0F00);
        run_op("R2 or",  6'd3, 32'hF0F0_0000, 32'h0000_0F0F, 6'd2, 32'hF0F0_0F0F);
        run_op("R2 xor", 6'd8, 32'hAAAA_5555, 32'hFFFF_0000, 6'd6, 32'h5555_5555);
        run_op("R3 clr", 6'd4, 32'h0000_00F0, 32'h0000_0FFF, 6'd7, 32'h0000_0F0F);
        run_op("R3 clr all", 6'd4, 32'hFFFF_FFFF, 32'h1234_5678, 6'd8, 32'd0);
    endtask

    task automatic t_compare();
        run_op("R4 eq true",  6'd5, 32'h1234_5678, 32'h1234_5678, 6'd9, 32'd1);
        run_op("R4 eq false", 6'd5, 32'h1234_5678, 32'h1234_5679, 6'd9, 32'd0);
        run_op("R4 lt signed", 6'd6, 32'hFFFF_FFFF, 32'd1, 6'd10, 32'd1);
        run_op("R4 ltu unsigned", 6'd7, 32'hFFFF_FFFF, 32'd1, 6'd11, 32'd0);
        run_op("R4 lt equal", 6'd6, 32'd4, 32'd4, 6'd12, 32'd0);
        run_op("R4 ltu true", 6'd7, 32'd1, 32'h8000_0000, 6'd13, 32'd1);
    endtask

    task automatic t_pass();
        run_op("R5 opa", 6'd9, 32'hDEAD_BEEF, 32'h1111_1111, 6'd14, 32'hDEAD_BEEF);
        run_op("R5 opb", 6'd10, 32'hDEAD_BEEF, 32'h1111_1111, 6'd15, 32'h1111_1111);
    endtask

    task automatic t_illegal(input logic [5:0] op);
        int w0;
        w0 = wr_seen;
        issue(op, 32'd1, 32'd2, 6'd20);
        chk("R9 busy after illegal accept", busy, 1);
        step();
        chk("R9 bad_op pulse", bad_op, 1);
        chk("R9 no write", wb_en, 0);
        chk("R9 no retire", retire, 0);
        step();
        chk("R9 bad_op one cycle", bad_op, 0);
        chk("R9 no retire after", retire, 0);
        chk("R9 idle", busy, 0);
        chk("R9 zero writes", wr_seen - w0, 0);
    endtask

    task automatic t_busy_ignore();
        int w0;
        w0 = wr_seen;
        issue(6'd0, 32'd100, 32'd1, 6'd30);
        op_sel = 6'd1; src_a = 32'd7; src_b = 32'd7; dest_idx = 6'd31;
        issue_valid = 1'b1;
        step();
        chk("R10 first data kept", wb_data, 32'd101);
        chk("R10 first address kept", wb_addr, 6'd30);
        step();
        chk("R10 retire of first", retire, 1);
        issue_valid = 1'b0;
        step();
        chk("R10 idle with no new job", busy, 0);
        step(); step();
        chk("R10 only one write", wr_seen - w0, 1);
    endtask

    task automatic t_reset_midflight();
        int w0;
        w0 = wr_seen;
        issue(6'd0, 32'd1, 32'd1, 6'd2);
        rst = 1'b1;
        step();
        rst = 1'b0;
        chk("R11 pending write dropped", wb_en, 0);
        chk("R11 busy cleared", busy, 0);
        step(); step();
        chk("R11 no retire after reset", retire, 0);
        chk("R11 no write after reset", wr_seen - w0, 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_arith();
        t_logic();
        t_compare();
        t_pass();
        t_illegal(6'd11);
        t_illegal(6'd63);
        t_busy_ignore();
        t_reset_midflight();
        run_op("R1 add after reset", 6'd0, 32'd2, 32'd3, 6'd0, 32'd5);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule